// File: doc/BRIEF.md
# Single-Level Timing Wheel Timer

This block manages many concurrent one-shot timers in hardware. Time is a ring of buckets with a pointer to the current slot. Each bucket heads a doubly linked list of timer records. The records come from a fixed on-chip pool. To start a timer, the client supplies a tick count and an identifier. The record goes to the bucket that many slots ahead of the pointer, at the head of that bucket's list, and the client gets back a record handle. To stop the timer early, the client presents that handle. The back links let the block remove the record in one cycle, wherever it sits in its list.

Each accepted tick moves the pointer forward one slot and wraps at the end of the ring. When the bucket under the pointer holds records, the block pops them one at a time, frees each one, and sends its identifier out on a valid/ready stream. A tick-ready output stays low while that bucket is not yet empty, so ticks cannot be lost. The record pool size, the ring length and the identifier width are parameters. The defaults are 8 buckets and 16 records.

Top module: `wheel_timer`

## Requirements
- R1: While reset is high and in the first cycle after it, exp_valid, start_rsp_valid and stop_rsp_valid are low, and tick_ready is high once reset is released.
- R2: Each cycle with start_valid high gives start_rsp_valid high in the next cycle, with start_err and start_handle. A timer accepted with interval j is reported after exactly the j-th accepted tick, counting a tick accepted in the same cycle as the start.
- R3: A start whose interval is 0, or is equal to or greater than the bucket count, is answered with start_err = 1 and never produces an expiry.
- R4: A start made while all records of the pool are in use is answered with start_err = 1.
- R5: A stop of an active handle is answered one cycle later with stop_rsp_valid = 1 and stop_err = 0, and that timer never expires.
- R6: A stop of a handle that is not active is answered with stop_err = 1 and changes no other timer.
- R7: If start_valid and stop_valid are high in the same cycle, the stop is carried out and the start is answered with start_err = 1.
- R8: All timers in the bucket reached by a tick are reported one per handshake, with the most recently started first.
- R9: tick_ready is low while the bucket under the pointer still holds records. A tick raised while tick_ready is low has no effect on the pointer.
- R10: The pointer advances by one on each accepted tick and wraps from the last bucket to bucket 0, so a bucket index of (pointer + interval) modulo the bucket count is reached after exactly interval ticks.
- R11: While exp_valid is high and exp_ready is low, exp_valid stays high and exp_id stays unchanged.
- R12: Records freed by a stop or an expiry can be started again, so after one stop, a start in a full pool succeeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_valid | input | 1 | Start request this cycle |
| start_interval | input | clog2(N_BKT)+1 | Ticks until expiry |
| start_id | input | ID_W | Identifier reported at expiry |
| start_rsp_valid | output | 1 | Start response valid |
| start_handle | output | clog2(POOL) | Record handle of the accepted start |
| start_err | output | 1 | Start was rejected |
| stop_valid | input | 1 | Stop request this cycle |
| stop_handle | input | clog2(POOL) | Handle of the timer to stop |
| stop_rsp_valid | output | 1 | Stop response valid |
| stop_err | output | 1 | Handle was not active |
| tick | input | 1 | Advance time by one slot |
| tick_ready | output | 1 | A tick will be accepted |
| exp_valid | output | 1 | Expired identifier valid |
| exp_id | output | ID_W | Identifier of the expired timer |
| exp_ready | input | 1 | Consumer accepts exp_id |

## Verification
Two collisions matter most. The first is a start and a tick in the same cycle. The bench raises both on one edge with interval 1 and requires the expiry to follow that same tick, because the bucket index is taken from the pointer before it moves. The second is a start and a stop in the same cycle. The bench starts a timer and then, in one cycle, stops it while issuing a second start. It expects stop_err = 0 and start_err = 1, and it expects no expiry from either timer over a full turn of the ring. A start issued while a drain is stalled by exp_ready is also judged: the ignored tick must not bring its expiry forward.

// File: rtl/wheel_pkg.sv
package wheel_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_LINK   = 2'd1,
    OP_UNLINK = 2'd2
  } link_op_e;
endpackage

// File: rtl/wheel_free_stack.sv
module wheel_free_stack #(
  parameter int POOL = 16,
  localparam int HW = $clog2(POOL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pop,
  input  logic          push,
  input  logic [HW-1:0] push_rec,
  output logic [HW-1:0] top_rec,
  output logic          empty
);
  localparam logic [HW-1:0] ONE_H = 1;
  localparam logic [HW:0]   FULL  = POOL[HW:0];
  localparam logic [HW:0]   ONE_C = 1;

  logic [HW-1:0] slots [POOL];
  logic [HW:0]   count;
  logic [HW-1:0] top_idx;

  assign top_idx = count[HW-1:0] - ONE_H;
  assign top_rec = slots[top_idx];
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= FULL;
      for (int i = 0; i < POOL; i++) slots[i] <= HW'(i);
    end else if (pop) begin
      count <= count - ONE_C;
    end else if (push) begin
      slots[count[HW-1:0]] <= push_rec;
      count <= count + ONE_C;
    end
  end
endmodule

// File: rtl/wheel_link_store.sv
module wheel_link_store import wheel_pkg::*; #(
  parameter int N_BKT = 8,
  parameter int POOL  = 16,
  parameter int ID_W  = 8,
  localparam int BW = $clog2(N_BKT),
  localparam int HW = $clog2(POOL)
) (
  input  logic            clk,
  input  logic            rst,
  input  link_op_e        op,
  input  logic [HW-1:0]   op_rec,
  input  logic [BW-1:0]   op_bkt,
  input  logic [ID_W-1:0] op_id,
  input  logic [BW-1:0]   rd_bkt,
  output logic [HW:0]     rd_head,
  output logic [ID_W-1:0] rd_head_id,
  input  logic [HW-1:0]   q_rec,
  output logic            q_act
);
  // link word: MSB set = points at a record, low bits = record index
  logic [HW:0]     heads [N_BKT];
  logic [HW:0]     nxt   [POOL];
  logic [HW:0]     prv   [POOL];
  logic [BW-1:0]   home  [POOL];
  logic [ID_W-1:0] tag   [POOL];
  logic [POOL-1:0] act;

  logic [HW:0] u_prv, u_nxt, l_head;

  assign u_prv      = prv[op_rec];
  assign u_nxt      = nxt[op_rec];
  assign l_head     = heads[op_bkt];
  assign rd_head    = heads[rd_bkt];
  assign rd_head_id = tag[rd_head[HW-1:0]];
  assign q_act      = act[q_rec];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < N_BKT; b++) heads[b] <= '0;
      act <= '0;
    end else begin
      case (op)
        OP_LINK: begin
          nxt[op_rec]  <= l_head;
          prv[op_rec]  <= '0;
          home[op_rec] <= op_bkt;
          tag[op_rec]  <= op_id;
          act[op_rec]  <= 1'b1;
          if (l_head[HW]) prv[l_head[HW-1:0]] <= {1'b1, op_rec};
          heads[op_bkt] <= {1'b1, op_rec};
        end
        OP_UNLINK: begin
          if (u_prv[HW]) nxt[u_prv[HW-1:0]] <= u_nxt;
          else           heads[home[op_rec]] <= u_nxt;
          if (u_nxt[HW]) prv[u_nxt[HW-1:0]] <= u_prv;
          act[op_rec] <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/wheel_timer.sv
module wheel_timer import wheel_pkg::*; #(
  parameter int N_BKT = 8,
  parameter int POOL  = 16,
  parameter int ID_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_valid,
  input  logic [$clog2(N_BKT):0]    start_interval,
  input  logic [ID_W-1:0]           start_id,
  output logic                      start_rsp_valid,
  output logic [$clog2(POOL)-1:0]   start_handle,
  output logic                      start_err,
  input  logic                      stop_valid,
  input  logic [$clog2(POOL)-1:0]   stop_handle,
  output logic                      stop_rsp_valid,
  output logic                      stop_err,
  input  logic                      tick,
  output logic                      tick_ready,
  output logic                      exp_valid,
  output logic [ID_W-1:0]           exp_id,
  input  logic                      exp_ready
);
  localparam int BW = $clog2(N_BKT);
  localparam int HW = $clog2(POOL);
  localparam logic [BW:0]   N_W   = N_BKT[BW:0];
  localparam logic [BW-1:0] LAST  = BW'(N_BKT - 1);
  localparam logic [BW-1:0] ONE_B = 1;

  logic [BW-1:0]   cur_ptr;
  logic [HW:0]     head_cur;
  logic [ID_W-1:0] head_id;
  logic [HW-1:0]   free_top;
  logic            pool_empty;
  logic            handle_live;
  logic            stop_ok, start_ok, pop_go, tick_go;
  logic [BW:0]     slot_sum;
  logic [BW-1:0]   link_bkt;
  link_op_e        op;
  logic [HW-1:0]   op_rec;
  logic [HW-1:0]   push_rec;

  assign stop_ok  = stop_valid && handle_live;
  assign start_ok = start_valid && !stop_valid && (start_interval != '0) &&
                    (start_interval < N_W) && !pool_empty;
  assign tick_ready = !head_cur[HW];
  assign tick_go    = tick && tick_ready;
  assign pop_go     = head_cur[HW] && !start_valid && !stop_valid &&
                      (!exp_valid || exp_ready);

  assign slot_sum = {1'b0, cur_ptr} + start_interval;
  assign link_bkt = (slot_sum >= N_W) ? BW'(slot_sum - N_W) : BW'(slot_sum);
  assign push_rec = stop_ok ? stop_handle : head_cur[HW-1:0];

  always_comb begin
    op     = OP_NONE;
    op_rec = stop_handle;
    if (stop_ok) begin
      op     = OP_UNLINK;
      op_rec = stop_handle;
    end else if (start_ok) begin
      op     = OP_LINK;
      op_rec = free_top;
    end else if (pop_go) begin
      op     = OP_UNLINK;
      op_rec = head_cur[HW-1:0];
    end
  end

  wheel_free_stack #(.POOL(POOL)) u_free (
    .clk      (clk),
    .rst      (rst),
    .pop      (start_ok),
    .push     (stop_ok || pop_go),
    .push_rec (push_rec),
    .top_rec  (free_top),
    .empty    (pool_empty)
  );

  wheel_link_store #(.N_BKT(N_BKT), .POOL(POOL), .ID_W(ID_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .op         (op),
    .op_rec     (op_rec),
    .op_bkt     (link_bkt),
    .op_id      (start_id),
    .rd_bkt     (cur_ptr),
    .rd_head    (head_cur),
    .rd_head_id (head_id),
    .q_rec      (stop_handle),
    .q_act      (handle_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_ptr         <= '0;
      start_rsp_valid <= 1'b0;
      start_err       <= 1'b0;
      start_handle    <= '0;
      stop_rsp_valid  <= 1'b0;
      stop_err        <= 1'b0;
      exp_valid       <= 1'b0;
      exp_id          <= '0;
    end else begin
      if (tick_go) cur_ptr <= (cur_ptr == LAST) ? '0 : cur_ptr + ONE_B;
      start_rsp_valid <= start_valid;
      start_err       <= start_valid && !start_ok;
      start_handle    <= free_top;
      stop_rsp_valid  <= stop_valid;
      stop_err        <= stop_valid && !stop_ok;
      if (pop_go) begin
        exp_valid <= 1'b1;
        exp_id    <= head_id;
      end else if (exp_ready) begin
        exp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wheel_timer_chk.sv
module wheel_timer_chk #(
  parameter int N_BKT = 8,
  parameter int ID_W  = 8,
  localparam int BW = $clog2(N_BKT)
) (
  input logic            clk,
  input logic            rst,
  input logic            start_valid,
  input logic [BW:0]     start_interval,
  input logic            stop_valid,
  input logic            start_rsp_valid,
  input logic            stop_rsp_valid,
  input logic            start_err,
  input logic            tick,
  input logic            tick_ready,
  input logic [BW-1:0]   cur_ptr,
  input logic            exp_valid,
  input logic            exp_ready,
  input logic [ID_W-1:0] exp_id
);
  localparam logic [BW:0]   N_W  = N_BKT[BW:0];
  localparam logic [BW-1:0] LAST = BW'(N_BKT - 1);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !exp_valid && !start_rsp_valid && !stop_rsp_valid);

  // R2
  start_answer_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> start_rsp_valid);

  // R3
  bad_interval_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid && (start_interval == '0 || start_interval >= N_W) |=> start_err);

  // R7
  start_stop_clash_chk: assert property (@(posedge clk) disable iff (rst)
    start_valid && stop_valid |=> start_err);

  // R9
  held_tick_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !tick_ready |=> $stable(cur_ptr));

  // R10
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick && tick_ready |=>
      cur_ptr == (($past(cur_ptr) == LAST) ? '0 : $past(cur_ptr) + 1'b1));

  // R11
  exp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    exp_valid && !exp_ready |=> exp_valid && $stable(exp_id));
endmodule

bind wheel_timer wheel_timer_chk #(.N_BKT(N_BKT), .ID_W(ID_W)) u_chk (
  .clk             (clk),
  .rst             (rst),
  .start_valid     (start_valid),
  .start_interval  (start_interval),
  .stop_valid      (stop_valid),
  .start_rsp_valid (start_rsp_valid),
  .stop_rsp_valid  (stop_rsp_valid),
  .start_err       (start_err),
  .tick            (tick),
  .tick_ready      (tick_ready),
  .cur_ptr         (cur_ptr),
  .exp_valid       (exp_valid),
  .exp_ready       (exp_ready),
  .exp_id          (exp_id)
);

// File: tb/wheel_timer_bench.sv
`timescale 1ns/1ps
module wheel_timer_bench;
  localparam int N_BKT = 8;
  localparam int POOL  = 16;
  localparam int ID_W  = 8;
  localparam int HW    = 4;
  localparam int IV_W  = 4;

  typedef struct packed {
    logic [IV_W-1:0] iv;
    logic            err;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{4'd0,  1'b1}, '{4'd1, 1'b0}, '{4'd3, 1'b0}, '{4'd7, 1'b0},
    '{4'd8,  1'b1}, '{4'd15, 1'b1}, '{4'd5, 1'b0}, '{4'd9, 1'b1}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start_valid = 1'b0;
  logic [IV_W-1:0] start_interval = '0;
  logic [ID_W-1:0] start_id = '0;
  logic            start_rsp_valid;
  logic [HW-1:0]   start_handle;
  logic            start_err;
  logic            stop_valid = 1'b0;
  logic [HW-1:0]   stop_handle = '0;
  logic            stop_rsp_valid;
  logic            stop_err;
  logic            tick = 1'b0;
  logic            tick_ready;
  logic            exp_valid;
  logic [ID_W-1:0] exp_id;
  logic            exp_ready = 1'b1;

  int nchk  = 0;
  int nfail = 0;
  int log_n = 0;
  logic [ID_W-1:0] log_id [64];
  logic [HW-1:0]   hnd [POOL];

  always #4 clk = ~clk;

  wheel_timer #(.N_BKT(N_BKT), .POOL(POOL), .ID_W(ID_W)) u_wheel_timer (
    .clk(clk), .rst(rst),
    .start_valid(start_valid), .start_interval(start_interval), .start_id(start_id),
    .start_rsp_valid(start_rsp_valid), .start_handle(start_handle), .start_err(start_err),
    .stop_valid(stop_valid), .stop_handle(stop_handle),
    .stop_rsp_valid(stop_rsp_valid), .stop_err(stop_err),
    .tick(tick), .tick_ready(tick_ready),
    .exp_valid(exp_valid), .exp_id(exp_id), .exp_ready(exp_ready)
  );

  always @(posedge clk) begin
    if (!rst && exp_valid && exp_ready) begin
      if (log_n < 64) log_id[log_n] = exp_id;
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input int iv, input int id, output logic [HW-1:0] h,
                          output logic e);
    @(negedge clk);
    start_valid = 1'b1; start_interval = IV_W'(iv); start_id = ID_W'(id);
    @(negedge clk);
    start_valid = 1'b0;
    h = start_handle; e = start_err;
  endtask

  task automatic do_stop(input logic [HW-1:0] h, output logic e);
    @(negedge clk);
    stop_valid = 1'b1; stop_handle = h;
    @(negedge clk);
    stop_valid = 1'b0;
    e = stop_err;
  endtask

  task automatic do_tick();
    @(negedge clk);
    while (!tick_ready) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    logic [HW-1:0] h;
    logic e, e2;
    int base;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tick_ready == 1'b1, "R1 tick_ready", int'(tick_ready), 1);
    chk(exp_valid == 1'b0, "R1 exp_valid", int'(exp_valid), 0);
    chk(start_rsp_valid == 1'b0, "R1 start_rsp_valid", int'(start_rsp_valid), 0);

    // vector table: interval legality (R3), then stop each accepted one (R5)
    for (int i = 0; i < 8; i++) begin
      do_start(int'(VECS[i].iv), 8'h80 + i, h, e);
      chk(start_rsp_valid == 1'b1, "R2 rsp", int'(start_rsp_valid), 1);
      chk(e == VECS[i].err, "R3 start_err", int'(e), int'(VECS[i].err));
      if (!e) begin
        do_stop(h, e2);
        chk(e2 == 1'b0, "R5 stop_err", int'(e2), 0);
      end
    end
    for (int t = 0; t < N_BKT; t++) do_tick();
    chk(log_n == 0, "R3 R5 no expiry", log_n, 0);

    // R2: interval 3 expires exactly on the third tick
    base = log_n;
    do_start(3, 8'h11, h, e);
    do_tick(); do_tick();
    chk(log_n == base, "R2 early", log_n, base);
    do_tick();
    chk(log_n == base + 1, "R2 count", log_n, base + 1);
    chk(log_id[base] == 8'h11, "R2 id", int'(log_id[base]), 8'h11);

    // R8 order, R11 hold, R9 held-off tick
    base = log_n;
    exp_ready = 1'b0;
    do_start(2, 8'h21, h, e);
    do_start(2, 8'h22, h, e);
    do_start(2, 8'h23, h, e);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk(exp_valid == 1'b1, "R8 valid", int'(exp_valid), 1);
    chk(exp_id == 8'h23, "R8 newest first", int'(exp_id), 8'h23);
    chk(tick_ready == 1'b0, "R9 tick_ready low", int'(tick_ready), 0);
    repeat (3) @(negedge clk);
    chk(exp_valid == 1'b1 && exp_id == 8'h23, "R11 hold", int'(exp_id), 8'h23);
    do_start(1, 8'h30, h, e);
    chk(e == 1'b0, "R2 start during drain", int'(e), 0);
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    exp_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(log_n == base + 3, "R9 ignored tick", log_n, base + 3);
    chk(log_id[base + 1] == 8'h22, "R8 second", int'(log_id[base + 1]), 8'h22);
    chk(log_id[base + 2] == 8'h21, "R8 third", int'(log_id[base + 2]), 8'h21);
    do_tick();
    chk(log_n == base + 4, "R9 later expiry", log_n, base + 4);
    chk(log_id[base + 3] == 8'h30, "R9 id", int'(log_id[base + 3]), 8'h30);

    // R4 pool exhaustion, R12 reuse, R6 stale stop
    base = log_n;
    for (int i = 0; i < POOL; i++) begin
      do_start(5, 8'h40 + i, h, e);
      hnd[i] = h;
      chk(e == 1'b0, "R4 fill", int'(e), 0);
    end
    do_start(5, 8'h5f, h, e);
    chk(e == 1'b1, "R4 full", int'(e), 1);
    do_stop(hnd[0], e);
    chk(e == 1'b0, "R12 stop", int'(e), 0);
    do_start(5, 8'h40, h, e);
    hnd[0] = h;
    chk(e == 1'b0, "R12 reuse", int'(e), 0);
    for (int i = 0; i < POOL; i++) begin
      do_stop(hnd[i], e);
      chk(e == 1'b0, "R5 stop all", int'(e), 0);
    end
    do_stop(hnd[3], e);
    chk(e == 1'b1, "R6 stale", int'(e), 1);
    for (int t = 0; t < N_BKT; t++) do_tick();
    chk(log_n == base, "R5 R6 none expired", log_n, base);

    // R7 start and stop together
    base = log_n;
    do_start(4, 8'h50, h, e);
    @(negedge clk);
    start_valid = 1'b1; start_interval = 4'd2; start_id = 8'h51;
    stop_valid = 1'b1; stop_handle = h;
    @(negedge clk);
    start_valid = 1'b0; stop_valid = 1'b0;
    chk(start_err == 1'b1, "R7 start_err", int'(start_err), 1);
    chk(stop_err == 1'b0, "R7 stop_err", int'(stop_err), 0);
    for (int t = 0; t < N_BKT; t++) do_tick();
    chk(log_n == base, "R7 no expiry", log_n, base);

    // R2 start with tick in one cycle; R10 wrap with interval 7
    base = log_n;
    @(negedge clk);
    while (!tick_ready) @(negedge clk);
    start_valid = 1'b1; start_interval = 4'd1; start_id = 8'h60; tick = 1'b1;
    @(negedge clk);
    start_valid = 1'b0; tick = 1'b0;
    repeat (4) @(negedge clk);
    chk(log_n == base + 1, "R2 same-cycle tick", log_n, base + 1);
    chk(log_id[base] == 8'h60, "R2 same-cycle id", int'(log_id[base]), 8'h60);
    do_start(7, 8'h61, h, e);
    for (int t = 0; t < 6; t++) do_tick();
    chk(log_n == base + 1, "R10 before wrap", log_n, base + 1);
    do_tick();
    chk(log_n == base + 2, "R10 after wrap", log_n, base + 2);
    chk(log_id[base + 1] == 8'h61, "R10 id", int'(log_id[base + 1]), 8'h61);

    summary();
    $finish;
  end
endmodule